// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus initiator and a bus target that run from unrelated clocks. Between them sits an unclocked request/acknowledge pair with a shared address bus, a direction line and a data bus. The link carries single reads and writes into a small register bank on the target side. Each side passes the other side's handshake line through a two-flop synchronizer before it acts on it.

A user on the initiator side pulses `startIn` with an address, a direction and write data. The initiator puts these on the bus and waits a fixed number of its own clock cycles so that targets can decode the address. It then raises request and waits for acknowledge. It drops request and waits for acknowledge to return low before it reports completion.

On a write, acknowledge means the target has stored the data. On a read, it means read data is valid on the bus, and the initiator samples the data before it drops request. An address that no target claims never gets an acknowledge. In that case the initiator gives up after a timeout, drops request and reports an error.

Top module: `hsBusLink`

## Requirements
- R1: After reset the link is idle: `busyOut`, `busReqOut`, `busAckOut`, `busOeOut` and `errOut` are all low.
- R2: A start accepted while idle puts its address on `busAddrOut` on the very next cycle. `busReqOut` then rises exactly SETTLE_CYC initiator cycles after the clock edge that accepted the start.
- R3: A write to an address whose upper bits (above the low log2(NUM_REGS) index bits) equal those of BASE_ADDR stores the write data in the register selected by the low index bits.
- R4: A read from a claimed address returns in `rdataOut` the value last written to that register, or zero if it has never been written. The read completes with `errOut` low.
- R5: Request falls only after acknowledge has been seen high, or after a timeout. `doneOut` is reported only once both `busReqOut` and `busAckOut` are low.
- R6: `busOeOut` (the target driving the data bus) is high only during a read that the target has claimed. It is never high during a write or an unclaimed access.
- R7: An access to an address that is not claimed gets no acknowledge. Request stays high for exactly TIMEOUT_CYC initiator cycles, and the transaction completes with `errOut` high. No target register changes.
- R8: A start pulse while `busyOut` is high is ignored. The bus address and direction hold their values until the current transaction is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mClk | input | 1 | Initiator clock |
| mRstN | input | 1 | Initiator reset, active low |
| sClk | input | 1 | Target clock |
| sRstN | input | 1 | Target reset, active low |
| startIn | input | 1 | Start a transaction (accepted when idle) |
| isWriteIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | ADDR_W | Transaction address |
| wdataIn | input | DATA_W | Write data |
| busyOut | output | 1 | Transaction in progress |
| doneOut | output | 1 | Transaction complete (one cycle) |
| errOut | output | 1 | Last transaction timed out |
| rdataOut | output | DATA_W | Data captured by the last read |
| busReqOut | output | 1 | Bus request line |
| busAckOut | output | 1 | Bus acknowledge line |
| busAddrOut | output | ADDR_W | Bus address lines |
| busOeOut | output | 1 | Target drives the data bus |

## Verification
The hardest case to reach is a start pulse that arrives in the middle of a handshake, while request is already high and the target is waiting to synchronize it. The bench injects such a pulse, with a different address, inside the request-high window of chosen transactions. It then checks that the bus address stays fixed and that the register bank holds only the intended writes. Timeouts come from addresses that no target claims, mixed into the random traffic. For these the bench counts the request-high window one cycle at a time against TIMEOUT_CYC, and it counts the settle window against SETTLE_CYC on every transaction.

// File: rtl/hsPkg.sv
package hsPkg;
  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_REQ, M_DROP} mState_t;

  typedef struct packed {
    logic latch;    // take a new command from the user
    logic capture;  // acknowledge seen while requesting
  } mStrobe_t;
endpackage

// File: rtl/hsSync.sv
module hsSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-2:0], din};
  end

  assign dout = shiftQ[STAGES-1];
endmodule

// File: rtl/hsMasterCtrl.sv
module hsMasterCtrl
  import hsPkg::*;
#(
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT_CYC = 24
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  input  logic     ackSync,
  output logic     reqOut,
  output logic     busyOut,
  output logic     doneOut,
  output logic     errOut,
  output mStrobe_t strobe
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);

  mState_t          state;
  logic [SET_W-1:0] setCnt;
  logic [TO_W-1:0]  toCnt;
  logic             errQ;

  assign strobe.latch   = (state == M_IDLE) && startIn;
  assign strobe.capture = (state == M_REQ) && ackSync;
  assign reqOut  = (state == M_REQ);
  assign busyOut = (state != M_IDLE);
  assign doneOut = (state == M_DROP) && !ackSync;
  assign errOut  = errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= M_IDLE;
      setCnt <= '0;
      toCnt  <= '0;
      errQ   <= 1'b0;
    end else begin
      unique case (state)
        M_IDLE: if (startIn) begin
          state  <= M_SETTLE;
          setCnt <= SET_W'(SETTLE_CYC - 1);
          errQ   <= 1'b0;
        end
        M_SETTLE: begin
          if (setCnt == '0) begin
            state <= M_REQ;
            toCnt <= '0;
          end else begin
            setCnt <= setCnt - 1'b1;
          end
        end
        M_REQ: begin
          if (ackSync) begin
            state <= M_DROP;
          end else if (toCnt == TO_W'(TIMEOUT_CYC - 1)) begin
            state <= M_DROP;
            errQ  <= 1'b1;
          end else begin
            toCnt <= toCnt + 1'b1;
          end
        end
        M_DROP: if (!ackSync) state <= M_IDLE;
        default: state <= M_IDLE;
      endcase
    end
  end

  // R5
  req_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqOut) |-> ($past(ackSync) || errQ));

  // R5
  idle_ack_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == M_IDLE) |-> !ackSync);
endmodule

// File: rtl/hsMasterDpath.sv
module hsMasterDpath
  import hsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mStrobe_t          strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              isWriteIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] addrQ,
  output logic              isWriteQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic [DATA_W-1:0] rdataQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      isWriteQ <= 1'b0;
      wdataQ   <= '0;
      rdataQ   <= '0;
    end else begin
      if (strobe.latch) begin
        addrQ    <= addrIn;
        isWriteQ <= isWriteIn;
        wdataQ   <= wdataIn;
      end
      if (strobe.capture && !isWriteQ) rdataQ <= busDataIn;
    end
  end
endmodule

// File: rtl/hsSlave.sv
module hsSlave #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int BASE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqAsync,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              isWriteIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ackOut,
  output logic              oeOut,
  output logic [DATA_W-1:0] rdataOut
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic              reqSync, selected, ackQ, oeQ;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] regs [NUM_REGS];

  hsSync #(.STAGES(2)) uReqSync (.clk(clk), .rstN(rstN), .din(reqAsync), .dout(reqSync));

  assign selected = (addrIn[ADDR_W-1:IDX_W] == BASE_V[ADDR_W-1:IDX_W]);
  assign idx      = addrIn[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ <= 1'b0;
      oeQ  <= 1'b0;
      rdQ  <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (!ackQ) begin
      if (reqSync && selected) begin
        ackQ <= 1'b1;
        if (isWriteIn) regs[idx] <= dataIn;
        else begin
          rdQ <= regs[idx];
          oeQ <= 1'b1;
        end
      end
    end else if (!reqSync) begin
      ackQ <= 1'b0;
      oeQ  <= 1'b0;
    end
  end

  assign ackOut   = ackQ;
  assign oeOut    = oeQ;
  assign rdataOut = rdQ;

  // R6
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> (!isWriteIn && selected));
endmodule

// File: rtl/hsBusLink.sv
module hsBusLink
  import hsPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 8,
  parameter int BASE_ADDR   = 'h40,
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT_CYC = 24
) (
  input  logic              mClk,
  input  logic              mRstN,
  input  logic              sClk,
  input  logic              sRstN,
  input  logic              startIn,
  input  logic              isWriteIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  output logic              busyOut,
  output logic              doneOut,
  output logic              errOut,
  output logic [DATA_W-1:0] rdataOut,
  output logic              busReqOut,
  output logic              busAckOut,
  output logic [ADDR_W-1:0] busAddrOut,
  output logic              busOeOut
);
  mStrobe_t          strobe;
  logic              req, ack, ackSync, dirWrite, sOe;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] mWdata, sRdata, busData;

  hsSync #(.STAGES(2)) uAckSync (.clk(mClk), .rstN(mRstN), .din(ack), .dout(ackSync));

  hsMasterCtrl #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk(mClk), .rstN(mRstN), .startIn(startIn), .ackSync(ackSync),
    .reqOut(req), .busyOut(busyOut), .doneOut(doneOut), .errOut(errOut), .strobe(strobe));

  hsMasterDpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(mClk), .rstN(mRstN), .strobe(strobe), .addrIn(addrIn), .isWriteIn(isWriteIn),
    .wdataIn(wdataIn), .busDataIn(busData), .addrQ(busAddr), .isWriteQ(dirWrite),
    .wdataQ(mWdata), .rdataQ(rdataOut));

  hsSlave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) uSlave (
    .clk(sClk), .rstN(sRstN), .reqAsync(req), .addrIn(busAddr), .isWriteIn(dirWrite),
    .dataIn(busData), .ackOut(ack), .oeOut(sOe), .rdataOut(sRdata));

  assign busData    = dirWrite ? mWdata : (sOe ? sRdata : '0);
  assign busReqOut  = req;
  assign busAckOut  = ack;
  assign busAddrOut = busAddr;
  assign busOeOut   = sOe;

  // R2
  req_addr_stable_chk: assert property (@(posedge mClk) disable iff (!mRstN)
    $rose(req) |-> $stable(busAddr));

  // R8
  busy_hold_chk: assert property (@(posedge mClk) disable iff (!mRstN)
    (busyOut && $past(busyOut)) |-> ($stable(busAddr) && $stable(dirWrite)));
endmodule

// File: tb/tb_hsBusLink.sv
module tb_hsBusLink;
  localparam int MCLK_PERIOD = 10;
  localparam int SCLK_PERIOD = 14;
  localparam int ADDR_W = 8, DATA_W = 16, NUM_REGS = 8, BASE = 'h40;
  localparam int SETTLE = 4, TMO = 24;

  logic mClk = 0, sClk = 0, mRstN = 0, sRstN = 0;
  logic startIn = 0, isWriteIn = 0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] wdataIn = '0;
  logic busyOut, doneOut, errOut, busReqOut, busAckOut, busOeOut;
  logic [DATA_W-1:0] rdataOut;
  logic [ADDR_W-1:0] busAddrOut;

  int nChecks = 0, nFails = 0;
  logic [DATA_W-1:0] model [NUM_REGS];

  always #(MCLK_PERIOD/2) mClk = ~mClk;
  always #(SCLK_PERIOD/2) sClk = ~sClk;

  hsBusLink #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE),
              .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) dut (
    .mClk(mClk), .mRstN(mRstN), .sClk(sClk), .sRstN(sRstN), .startIn(startIn),
    .isWriteIn(isWriteIn), .addrIn(addrIn), .wdataIn(wdataIn), .busyOut(busyOut),
    .doneOut(doneOut), .errOut(errOut), .rdataOut(rdataOut), .busReqOut(busReqOut),
    .busAckOut(busAckOut), .busAddrOut(busAddrOut), .busOeOut(busOeOut));

  function automatic bit claimed(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:3] == 5'(BASE >> 3));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  task automatic txn(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                     input bit poke);
    int n, h, guard;
    bit sawOe, sawAck, hit;
    hit = claimed(a);
    @(negedge mClk);
    startIn = 1; isWriteIn = wr; addrIn = a; wdataIn = d;
    @(negedge mClk);
    startIn = 0;
    check(busAddrOut == a, "R2 addr", busAddrOut, a);
    n = 0;
    while (!busReqOut && n < 100) begin @(negedge mClk); n++; end
    check(n == SETTLE, "R2 settle", n, SETTLE);
    h = 0; sawOe = 0; sawAck = 0;
    while (busReqOut && h < 200) begin
      if (busOeOut) sawOe = 1;
      if (busAckOut) sawAck = 1;
      if (poke && h == 1) begin startIn = 1; addrIn = ~a; isWriteIn = ~wr; end
      else startIn = 0;
      @(negedge mClk); h++;
    end
    startIn = 0;
    guard = 0;
    while (!doneOut && guard < 200) begin
      if (busOeOut) sawOe = 1;
      if (busAckOut) sawAck = 1;
      @(negedge mClk); guard++;
    end
    check(doneOut && !busReqOut && !busAckOut, "R5 return to zero",
          {doneOut, busReqOut, busAckOut}, 3'b100);
    check(sawOe == (hit && !wr), "R6 oe", sawOe, hit && !wr);
    if (poke) check(busAddrOut == a, "R8 addr held", busAddrOut, a);
    if (!hit) begin
      check(!sawAck && h == TMO, "R7 timeout window", h, TMO);
      check(errOut == 1, "R7 err", errOut, 1);
    end else begin
      check(errOut == 0, "R4 err low", errOut, 0);
      if (wr) model[a[2:0]] = d;
      else check(rdataOut == model[a[2:0]], "R3/R4 read data", rdataOut, model[a[2:0]]);
    end
    @(negedge mClk);
  endtask

  initial begin
    #(MCLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
    repeat (4) @(negedge mClk);
    mRstN = 1; sRstN = 1;
    @(negedge mClk);
    // R1 reset state
    check({busyOut, busReqOut, busAckOut, busOeOut, errOut} == 5'b0, "R1 reset",
          {busyOut, busReqOut, busAckOut, busOeOut, errOut}, 0);
    // R4 unwritten register reads zero
    txn(0, 8'h43, 0, 0);
    // R3 boundary registers
    txn(1, 8'h40, 16'hA5A5, 0);
    txn(1, 8'h47, 16'h5A5A, 0);
    txn(0, 8'h40, 0, 0);
    txn(0, 8'h47, 0, 0);
    // R7 unclaimed neighbours just outside the range
    txn(1, 8'h48, 16'hDEAD, 0);
    txn(0, 8'h3F, 0, 0);
    txn(0, 8'h47, 0, 0);
    // R8 start during a live handshake
    txn(1, 8'h42, 16'h1234, 1);
    txn(0, 8'h42, 0, 1);
    for (int i = 0; i < NUM_REGS; i++) txn(0, 8'(BASE + i), 0, 0);
    for (int k = 0; k < 60; k++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom % 6 == 0) ? 8'($urandom) : 8'(BASE + ($urandom % NUM_REGS));
      txn($urandom % 2, a, 16'($urandom), ($urandom % 8) == 0);
    end
    for (int i = 0; i < NUM_REGS; i++) txn(0, 8'(BASE + i), 0, 0);
    summary();
    $finish;
  end
endmodule